// File: doc/BRIEF.md
# Software-Loaded Translation Buffer with Paired Pages

This block is a small, fully associative address translation buffer. System software fills and inspects it. There is no hardware page walker. Each slot describes a naturally aligned pair of pages that share one virtual page number. The even page and the odd page each have their own physical frame, cache attribute, dirty bit and valid bit. A per-slot size mask makes chosen low virtual page bits don't-care, so one slot can cover a larger page pair. A global bit lets a slot match under any address-space identifier.

Software drives a one-cycle command port with four operations: indexed write, indexed read, probe and flush-all. The response is registered and appears one cycle after the command. Slot contents travel in four 32-bit words: a size word, a tag word and two frame words.

A separate lookup port is purely combinational and always sees the table as it stands before any command in the same cycle lands. It returns hit, physical address, cache attribute and dirty bit. It also handles three other cases:
- In physical mode it passes the address straight through.
- It flags addresses in the uncached region.
- It reports a fault for a data access whose byte range wraps past the top of the address space.

Top module: `tlb_paired`

## Requirements
- R1: A slot's virtual page number (address bits 31:13) matches the request on every bit where the slot's size mask is 0; a mask bit of 1 makes that bit don't-care.
- R2: A page-number match counts only when the slot's global bit is 1 or its stored identifier equals `lk_asid`.
- R3: A probe (cmd_op 2) returns on `rsp_index` the lowest matching slot index, or all ones (4'hF) when no slot matches.
- R4: A slot whose even and odd valid bits are both 0 never matches, neither for lookup nor for probe; after reset all slots are in this state.
- R5: An indexed write (cmd_op 0) replaces the slot at `cmd_index`; an index of ENTRIES or more changes no slot and sets `rsp_err`.
- R6: Flush-all (cmd_op 3) zeroes every slot, including both valid bits, and returns the replacement pointer to 0.
- R7: Word layout, used both for writes and for read responses (cmd_op 1):
  - size word = mask << 11;
  - tag word = (page number << 11) | identifier in bits 7:0;
  - frame word = (frame << 6) | cache attribute in bits 5:3 | dirty in bit 2 | valid in bit 1 | global in bit 0.
  The global bit of a write is the AND of bit 0 of both frame words.
- R8: `lk_uncached` is 1 exactly when bits 31 and 29 of `lk_vaddr` are both 1, in every mode.
- R9: With `lk_phys` = 1 the lookup reports a hit with `lk_paddr` equal to `lk_vaddr`, zero attributes and no fault.
- R10: With `lk_phys` = 0, `lk_data` = 1 and a nonzero `lk_size`: if `lk_vaddr` + `lk_size` − 1 overflows 32 bits, `lk_wrap_fault` is 1 and there is no hit.
- R11: A read with `cmd_advance` = 1 returns the slot at the replacement pointer and reports that index, then moves the pointer by one modulo ENTRIES. No other command moves the pointer, except flush.
- R12: On a match, the page-number bit just above the mask's ones selects the odd (1) or even (0) frame. A cleared valid bit on the selected frame gives `lk_inval` = 1 and no hit. On a hit, `lk_paddr` takes the frame bits above the masked span and the request's bits below it.
- R13: When several slots match a lookup, the lowest-numbered slot supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 write, 1 read, 2 probe, 3 flush |
| cmd_index | input | 4 | Slot index for write and read |
| cmd_advance | input | 1 | Read uses and advances the replacement pointer |
| cmd_mask_word | input | 32 | Size word for write |
| cmd_vpn_word | input | 32 | Tag word for write and probe |
| cmd_frame0_word | input | 32 | Even frame word for write |
| cmd_frame1_word | input | 32 | Odd frame word for write |
| rsp_valid | output | 1 | Response to last cycle's command |
| rsp_err | output | 1 | Index out of range |
| rsp_index | output | 4 | Slot used, or probe result |
| rsp_mask_word | output | 32 | Size word read back |
| rsp_vpn_word | output | 32 | Tag word read back |
| rsp_frame0_word | output | 32 | Even frame word read back |
| rsp_frame1_word | output | 32 | Odd frame word read back |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Current address-space identifier |
| lk_phys | input | 1 | Physical mode, bypass translation |
| lk_data | input | 1 | Data access (enables wrap check) |
| lk_size | input | 4 | Access size in bytes |
| lk_hit | output | 1 | Translation valid |
| lk_inval | output | 1 | Match on a page whose valid bit is clear |
| lk_wrap_fault | output | 1 | Access range wraps the address space |
| lk_uncached | output | 1 | Address lies in the uncached region |
| lk_paddr | output | 32 | Physical address |
| lk_cattr | output | 3 | Cache attribute of the page |
| lk_dirty | output | 1 | Dirty bit of the page |

## Verification
A lookup and a table-changing command can share a cycle. The bench drives a write that retargets slot 0, and later a flush, while the lookup port asks for an address that slot 0 maps. The lookup must return the old translation in that cycle and the new result only in the next one. The behavioural model applies commands only at the clock edge and compares the combinational outputs before it, so any early pass-through of the new contents is reported.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W      = 32;
    localparam int PG_BITS   = 12;
    localparam int VPN_W     = VA_W - PG_BITS - 1;
    localparam int PFN_W     = VA_W - PG_BITS;
    localparam int ASID_W    = 8;
    localparam int CA_W      = 3;
    localparam int SIZE_W    = 4;
    localparam int WORD_W    = 32;
    localparam int HI_SHIFT  = 11;
    localparam int PFN_SHIFT = 6;
    localparam logic [VA_W-1:0] UNC_PAT = 32'hA000_0000;

    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        logic [CA_W-1:0]  cattr;
        logic             dirty;
        logic             valid;
    } tlb_page_t;

    typedef struct packed {
        logic [VPN_W-1:0]  mask;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic              glob;
        tlb_page_t         even;
        tlb_page_t         odd;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        CMD_WRITE = 2'd0,
        CMD_READ  = 2'd1,
        CMD_PROBE = 2'd2,
        CMD_FLUSH = 2'd3
    } tlb_cmd_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  tlb_entry_t [ENTRIES-1:0] tbl_i,
    input  logic [VPN_W-1:0]         vpn_i,
    input  logic [ASID_W-1:0]        asid_i,
    output logic [ENTRIES-1:0]       hit_o
);
    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_ent
        tlb_entry_t e;
        logic       occ;
        logic       tag_eq;
        logic       id_ok;
        assign e      = tbl_i[gi];
        assign occ    = e.even.valid | e.odd.valid;
        assign tag_eq = ((vpn_i ^ e.vpn) & ~e.mask) == '0;
        assign id_ok  = e.glob || (e.asid == asid_i);
        assign hit_o[gi] = occ && tag_eq && id_ok;
    end
endmodule

// File: rtl/tlb_first.sv
module tlb_first #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IW'(i);
        end
    end
    assign found_o = |req_i;
endmodule

// File: rtl/tlb_front.sv
module tlb_front
    import tlb_pkg::*;
(
    input  logic [VA_W-1:0]   vaddr_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              phys_i,
    input  logic              data_i,
    input  logic              found_i,
    input  tlb_entry_t        ent_i,
    output logic              hit_o,
    output logic              inval_o,
    output logic              wrap_o,
    output logic              unc_o,
    output logic [VA_W-1:0]   paddr_o,
    output logic [CA_W-1:0]   cattr_o,
    output logic              dirty_o
);
    logic [PFN_W-1:0] vpage;
    logic [PFN_W-1:0] offm;
    logic [PFN_W-1:0] selm;
    logic             odd;
    tlb_page_t        pg;
    logic [VA_W:0]    last;
    logic             wraps;

    always_comb begin
        vpage = vaddr_i[VA_W-1:PG_BITS];
        offm  = {1'b0, ent_i.mask};
        selm  = ~offm & {ent_i.mask, 1'b1};
        odd   = |(vpage & selm);
        pg    = odd ? ent_i.odd : ent_i.even;
        last  = {1'b0, vaddr_i} + (VA_W+1)'(size_i) - (VA_W+1)'(1);
        wraps = data_i && (size_i != '0) && last[VA_W];
        unc_o = (vaddr_i & UNC_PAT) == UNC_PAT;

        hit_o   = 1'b0;
        inval_o = 1'b0;
        wrap_o  = 1'b0;
        paddr_o = '0;
        cattr_o = '0;
        dirty_o = 1'b0;
        if (phys_i) begin
            hit_o   = 1'b1;
            paddr_o = vaddr_i;
        end else if (wraps) begin
            wrap_o = 1'b1;
        end else if (found_i) begin
            if (pg.valid) begin
                hit_o   = 1'b1;
                paddr_o = {(pg.pfn & ~offm) | (vpage & offm), vaddr_i[PG_BITS-1:0]};
                cattr_o = pg.cattr;
                dirty_o = pg.dirty;
            end else begin
                inval_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tlb_paired.sv
module tlb_paired
    import tlb_pkg::*;
#(
    parameter  int ENTRIES = 8,
    localparam int IDX_W   = $clog2(ENTRIES) + 1,
    localparam int PTR_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [IDX_W-1:0]   cmd_index,
    input  logic               cmd_advance,
    input  logic [WORD_W-1:0]  cmd_mask_word,
    input  logic [WORD_W-1:0]  cmd_vpn_word,
    input  logic [WORD_W-1:0]  cmd_frame0_word,
    input  logic [WORD_W-1:0]  cmd_frame1_word,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [IDX_W-1:0]   rsp_index,
    output logic [WORD_W-1:0]  rsp_mask_word,
    output logic [WORD_W-1:0]  rsp_vpn_word,
    output logic [WORD_W-1:0]  rsp_frame0_word,
    output logic [WORD_W-1:0]  rsp_frame1_word,
    input  logic [VA_W-1:0]    lk_vaddr,
    input  logic [ASID_W-1:0]  lk_asid,
    input  logic               lk_phys,
    input  logic               lk_data,
    input  logic [SIZE_W-1:0]  lk_size,
    output logic               lk_hit,
    output logic               lk_inval,
    output logic               lk_wrap_fault,
    output logic               lk_uncached,
    output logic [VA_W-1:0]    lk_paddr,
    output logic [CA_W-1:0]    lk_cattr,
    output logic               lk_dirty
);
    typedef struct packed {
        tlb_entry_t [ENTRIES-1:0] tbl;
        logic [PTR_W-1:0]         ptr;
        logic                     rsp_valid;
        logic                     rsp_err;
        logic [IDX_W-1:0]         rsp_idx;
        logic [WORD_W-1:0]        w_mask;
        logic [WORD_W-1:0]        w_vpn;
        logic [WORD_W-1:0]        w_f0;
        logic [WORD_W-1:0]        w_f1;
    } state_t;

    state_t st_q, st_d;

    function automatic logic [WORD_W-1:0] frame_word(tlb_page_t p, logic g);
        return (WORD_W'(p.pfn) << PFN_SHIFT) | WORD_W'({p.cattr, p.dirty, p.valid, g});
    endfunction

    function automatic tlb_page_t frame_decode(logic [WORD_W-1:0] w);
        tlb_page_t p;
        p.pfn   = w[PFN_SHIFT +: PFN_W];
        p.cattr = w[3 +: CA_W];
        p.dirty = w[2];
        p.valid = w[1];
        return p;
    endfunction

    // ---------------- lookup path ----------------
    logic [ENTRIES-1:0] lk_match;
    logic               lk_found;
    logic [PTR_W-1:0]   lk_idx;

    tlb_match #(.ENTRIES(ENTRIES)) u_lk_match (
        .tbl_i  (st_q.tbl),
        .vpn_i  (lk_vaddr[VA_W-1 -: VPN_W]),
        .asid_i (lk_asid),
        .hit_o  (lk_match)
    );

    tlb_first #(.N(ENTRIES), .IW(PTR_W)) u_lk_first (
        .req_i   (lk_match),
        .found_o (lk_found),
        .idx_o   (lk_idx)
    );

    tlb_front u_front (
        .vaddr_i (lk_vaddr),
        .size_i  (lk_size),
        .phys_i  (lk_phys),
        .data_i  (lk_data),
        .found_i (lk_found),
        .ent_i   (st_q.tbl[lk_idx]),
        .hit_o   (lk_hit),
        .inval_o (lk_inval),
        .wrap_o  (lk_wrap_fault),
        .unc_o   (lk_uncached),
        .paddr_o (lk_paddr),
        .cattr_o (lk_cattr),
        .dirty_o (lk_dirty)
    );

    // ---------------- probe path ----------------
    logic [ENTRIES-1:0] pr_match;
    logic               pr_found;
    logic [PTR_W-1:0]   pr_idx;

    tlb_match #(.ENTRIES(ENTRIES)) u_pr_match (
        .tbl_i  (st_q.tbl),
        .vpn_i  (cmd_vpn_word[HI_SHIFT +: VPN_W]),
        .asid_i (cmd_vpn_word[ASID_W-1:0]),
        .hit_o  (pr_match)
    );

    tlb_first #(.N(ENTRIES), .IW(PTR_W)) u_pr_first (
        .req_i   (pr_match),
        .found_o (pr_found),
        .idx_o   (pr_idx)
    );

    // ---------------- command path ----------------
    logic       idx_ok;
    tlb_entry_t wr_ent;
    tlb_entry_t rd_ent;
    logic [IDX_W-1:0] rd_idx;

    assign idx_ok = cmd_index < IDX_W'(ENTRIES);

    always_comb begin
        wr_ent.mask = cmd_mask_word[HI_SHIFT +: VPN_W];
        wr_ent.vpn  = cmd_vpn_word[HI_SHIFT +: VPN_W];
        wr_ent.asid = cmd_vpn_word[ASID_W-1:0];
        wr_ent.glob = cmd_frame0_word[0] & cmd_frame1_word[0];
        wr_ent.even = frame_decode(cmd_frame0_word);
        wr_ent.odd  = frame_decode(cmd_frame1_word);
    end

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.rsp_err   = 1'b0;
        st_d.rsp_idx   = '0;
        st_d.w_mask    = '0;
        st_d.w_vpn     = '0;
        st_d.w_f0      = '0;
        st_d.w_f1      = '0;
        rd_idx         = cmd_advance ? {1'b0, st_q.ptr} : cmd_index;
        rd_ent         = st_q.tbl[rd_idx[PTR_W-1:0]];
        if (cmd_valid) begin
            st_d.rsp_valid = 1'b1;
            case (tlb_cmd_e'(cmd_op))
                CMD_WRITE: begin
                    st_d.rsp_idx = cmd_index;
                    if (idx_ok) st_d.tbl[cmd_index[PTR_W-1:0]] = wr_ent;
                    else        st_d.rsp_err = 1'b1;
                end
                CMD_READ: begin
                    st_d.rsp_idx = rd_idx;
                    if (rd_idx < IDX_W'(ENTRIES)) begin
                        st_d.w_mask = WORD_W'(rd_ent.mask) << HI_SHIFT;
                        st_d.w_vpn  = (WORD_W'(rd_ent.vpn) << HI_SHIFT) | WORD_W'(rd_ent.asid);
                        st_d.w_f0   = frame_word(rd_ent.even, rd_ent.glob);
                        st_d.w_f1   = frame_word(rd_ent.odd, rd_ent.glob);
                    end else begin
                        st_d.rsp_err = 1'b1;
                    end
                    if (cmd_advance) begin
                        st_d.ptr = (st_q.ptr == PTR_W'(ENTRIES - 1)) ? '0 : st_q.ptr + 1'b1;
                    end
                end
                CMD_PROBE: begin
                    st_d.rsp_idx = pr_found ? {1'b0, pr_idx} : '1;
                end
                default: begin
                    st_d.tbl = '0;
                    st_d.ptr = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid       = st_q.rsp_valid;
    assign rsp_err         = st_q.rsp_err;
    assign rsp_index       = st_q.rsp_idx;
    assign rsp_mask_word   = st_q.w_mask;
    assign rsp_vpn_word    = st_q.w_vpn;
    assign rsp_frame0_word = st_q.w_f0;
    assign rsp_frame1_word = st_q.w_f1;

    logic unused_cmd_bits;
    assign unused_cmd_bits = ^{cmd_mask_word[HI_SHIFT-1:0],
                               cmd_mask_word[WORD_W-1:HI_SHIFT+VPN_W],
                               cmd_vpn_word[HI_SHIFT-1:ASID_W],
                               cmd_vpn_word[WORD_W-1:HI_SHIFT+VPN_W],
                               cmd_frame0_word[WORD_W-1:PFN_SHIFT+PFN_W],
                               cmd_frame1_word[WORD_W-1:PFN_SHIFT+PFN_W]};

    // ---------------- assertions ----------------
    AST_OOR_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == CMD_WRITE && !idx_ok) |=> ($stable(st_q.tbl) && rsp_err)); // R5
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == CMD_FLUSH) |=> (st_q.ptr == '0 && (lk_phys || !(lk_hit || lk_inval)))); // R6
    AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cmd_valid && ((cmd_op == CMD_READ && cmd_advance) || cmd_op == CMD_FLUSH))) |=> $stable(st_q.ptr)); // R11
    AST_PHYS_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        lk_phys |-> (lk_hit && lk_paddr == lk_vaddr && !lk_wrap_fault)); // R9
    AST_WRAP_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_wrap_fault |-> (!lk_hit && lk_data && !lk_phys)); // R10
    AST_INVAL_NOT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_inval |-> (!lk_hit && lk_paddr == '0)); // R12
endmodule

// File: tb/tlb_paired_tb.sv
module tlb_paired_tb;
    import tlb_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int IW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic cmd_valid = 0; logic [1:0] cmd_op = 0; logic [IW-1:0] cmd_index = 0; logic cmd_advance = 0;
    logic [31:0] cmd_mask_word = 0, cmd_vpn_word = 0, cmd_frame0_word = 0, cmd_frame1_word = 0;
    logic rsp_valid, rsp_err; logic [IW-1:0] rsp_index;
    logic [31:0] rsp_mask_word, rsp_vpn_word, rsp_frame0_word, rsp_frame1_word;
    logic [31:0] lk_vaddr = 0; logic [7:0] lk_asid = 0; logic lk_phys = 0, lk_data = 0; logic [3:0] lk_size = 1;
    logic lk_hit, lk_inval, lk_wrap_fault, lk_uncached, lk_dirty;
    logic [31:0] lk_paddr; logic [2:0] lk_cattr;

    tlb_paired #(.ENTRIES(N)) u_dut (.*);

    int checks = 0, fails = 0;

    // behavioural model
    logic [VPN_W-1:0] m_mask [N]; logic [VPN_W-1:0] m_vpn [N];
    logic [7:0] m_asid [N]; logic m_g [N];
    logic [PFN_W-1:0] m_pfn [N][2]; logic [2:0] m_c [N][2]; logic m_d [N][2]; logic m_v [N][2];
    int m_ptr = 0;

    logic e_hit, e_inv, e_wr, e_unc, e_dy; logic [31:0] e_pa; logic [2:0] e_ca;
    logic r_v, r_err; logic [IW-1:0] r_idx; logic [31:0] r_w0, r_w1, r_w2, r_w3;

    function automatic logic [31:0] frame(logic [PFN_W-1:0] p, logic [2:0] c, logic d, logic v, logic g);
        return (32'(p) << 6) | (32'(c) << 3) | (32'(d) << 2) | (32'(v) << 1) | 32'(g);
    endfunction

    function automatic int find(logic [VPN_W-1:0] vpn, logic [7:0] asid);
        for (int i = 0; i < N; i++) begin
            int k;
            if (!(m_v[i][0] || m_v[i][1])) continue;
            if (!m_g[i] && m_asid[i] != asid) continue;
            k = $countones(m_mask[i]);
            if ((vpn >> k) != (m_vpn[i] >> k)) continue;
            return i;
        end
        return -1;
    endfunction

    task automatic ref_lookup();
        int i, k, s; logic [63:0] offm;
        e_hit = 0; e_inv = 0; e_wr = 0; e_dy = 0; e_pa = 0; e_ca = 0;
        e_unc = (lk_vaddr & 32'hA000_0000) == 32'hA000_0000;
        if (lk_phys) begin e_hit = 1; e_pa = lk_vaddr; return; end
        if (lk_data && lk_size != 0 && (64'(lk_vaddr) + 64'(lk_size) - 1 > 64'hFFFF_FFFF)) begin
            e_wr = 1; return;
        end
        i = find(lk_vaddr[31:13], lk_asid);
        if (i < 0) return;
        k = $countones(m_mask[i]);
        s = int'(lk_vaddr[12 + k]);
        if (!m_v[i][s]) begin e_inv = 1; return; end
        offm = (64'd1 << (12 + k)) - 1;
        e_hit = 1;
        e_pa = 32'(((64'(m_pfn[i][s]) << 12) & ~offm) | (64'(lk_vaddr) & offm));
        e_ca = m_c[i][s]; e_dy = m_d[i][s];
    endtask

    task automatic ref_command();
        int ri, pi;
        r_v = cmd_valid; r_err = 0; r_idx = 0; r_w0 = 0; r_w1 = 0; r_w2 = 0; r_w3 = 0;
        if (!cmd_valid) return;
        case (cmd_op)
            2'd0: begin
                r_idx = cmd_index;
                if (cmd_index < N) begin
                    ri = int'(cmd_index);
                    m_mask[ri] = cmd_mask_word[29:11]; m_vpn[ri] = cmd_vpn_word[29:11];
                    m_asid[ri] = cmd_vpn_word[7:0];
                    m_g[ri] = cmd_frame0_word[0] && cmd_frame1_word[0];
                    m_pfn[ri][0] = cmd_frame0_word[25:6]; m_c[ri][0] = cmd_frame0_word[5:3];
                    m_d[ri][0] = cmd_frame0_word[2]; m_v[ri][0] = cmd_frame0_word[1];
                    m_pfn[ri][1] = cmd_frame1_word[25:6]; m_c[ri][1] = cmd_frame1_word[5:3];
                    m_d[ri][1] = cmd_frame1_word[2]; m_v[ri][1] = cmd_frame1_word[1];
                end else r_err = 1;
            end
            2'd1: begin
                ri = cmd_advance ? m_ptr : int'(cmd_index);
                r_idx = IW'(ri);
                if (ri < N) begin
                    r_w0 = 32'(m_mask[ri]) << 11;
                    r_w1 = (32'(m_vpn[ri]) << 11) | 32'(m_asid[ri]);
                    r_w2 = frame(m_pfn[ri][0], m_c[ri][0], m_d[ri][0], m_v[ri][0], m_g[ri]);
                    r_w3 = frame(m_pfn[ri][1], m_c[ri][1], m_d[ri][1], m_v[ri][1], m_g[ri]);
                end else r_err = 1;
                if (cmd_advance) m_ptr = (m_ptr + 1) % N;
            end
            2'd2: begin
                pi = find(cmd_vpn_word[29:11], cmd_vpn_word[7:0]);
                r_idx = (pi < 0) ? '1 : IW'(pi);
            end
            default: begin
                for (int j = 0; j < N; j++) begin
                    m_mask[j] = 0; m_vpn[j] = 0; m_asid[j] = 0; m_g[j] = 0;
                    for (int h = 0; h < 2; h++) begin
                        m_pfn[j][h] = 0; m_c[j][h] = 0; m_d[j][h] = 0; m_v[j][h] = 0;
                    end
                end
                m_ptr = 0;
            end
        endcase
    endtask

    // one cycle: inputs already driven just after a falling edge
    task automatic tick(input string tag);
        #1;
        ref_lookup();
        checks++;
        if ({lk_hit, lk_paddr, lk_cattr, lk_dirty, lk_inval, lk_wrap_fault, lk_uncached} !==
            {e_hit, e_pa, e_ca, e_dy, e_inv, e_wr, e_unc}) begin
            fails++;
            $display("FAIL %s lookup va=%h: got hit=%b pa=%h c=%0d d=%b inv=%b wrap=%b unc=%b, expected hit=%b pa=%h c=%0d d=%b inv=%b wrap=%b unc=%b",
                     tag, lk_vaddr, lk_hit, lk_paddr, lk_cattr, lk_dirty, lk_inval, lk_wrap_fault, lk_uncached,
                     e_hit, e_pa, e_ca, e_dy, e_inv, e_wr, e_unc);
        end
        ref_command();
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (rsp_valid !== r_v || (r_v && {rsp_err, rsp_index, rsp_mask_word, rsp_vpn_word, rsp_frame0_word, rsp_frame1_word} !==
                                         {r_err, r_idx, r_w0, r_w1, r_w2, r_w3})) begin
            fails++;
            $display("FAIL %s response: got v=%b err=%b idx=%h w=%h %h %h %h, expected v=%b err=%b idx=%h w=%h %h %h %h",
                     tag, rsp_valid, rsp_err, rsp_index, rsp_mask_word, rsp_vpn_word, rsp_frame0_word, rsp_frame1_word,
                     r_v, r_err, r_idx, r_w0, r_w1, r_w2, r_w3);
        end
        cmd_valid = 0; cmd_advance = 0;
    endtask

    task automatic look(input logic [31:0] va, input logic [7:0] asid, input logic phys = 0,
                        input logic data = 0, input logic [3:0] size = 1);
        lk_vaddr = va; lk_asid = asid; lk_phys = phys; lk_data = data; lk_size = size;
    endtask

    task automatic cwr(input logic [3:0] idx, input logic [VPN_W-1:0] mask, input logic [VPN_W-1:0] vpn,
                       input logic [7:0] asid, input logic g,
                       input logic [PFN_W-1:0] p0, input logic [2:0] c0, input logic d0, input logic v0,
                       input logic [PFN_W-1:0] p1, input logic [2:0] c1, input logic d1, input logic v1);
        cmd_valid = 1; cmd_op = 2'd0; cmd_index = idx;
        cmd_mask_word = 32'(mask) << 11;
        cmd_vpn_word = (32'(vpn) << 11) | 32'(asid);
        cmd_frame0_word = frame(p0, c0, d0, v0, g);
        cmd_frame1_word = frame(p1, c1, d1, v1, g);
    endtask

    task automatic crd(input logic [3:0] idx, input logic adv);
        cmd_valid = 1; cmd_op = 2'd1; cmd_index = idx; cmd_advance = adv;
    endtask

    task automatic cpr(input logic [VPN_W-1:0] vpn, input logic [7:0] asid);
        cmd_valid = 1; cmd_op = 2'd2; cmd_vpn_word = (32'(vpn) << 11) | 32'(asid);
    endtask

    task automatic cfl();
        cmd_valid = 1; cmd_op = 2'd3;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: run did not complete in time");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int j = 0; j < N; j++) begin
            m_mask[j] = 0; m_vpn[j] = 0; m_asid[j] = 0; m_g[j] = 0;
            for (int h = 0; h < 2; h++) begin
                m_pfn[j][h] = 0; m_c[j][h] = 0; m_d[j][h] = 0; m_v[j][h] = 0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1;

        // reset state: empty table, no response
        look(32'h0000_0000, 8'd0); tick("R4");
        crd(4'd3, 0); tick("R6");

        // slot 0, lookup in the same cycle still misses
        look(32'h0040_2ABC, 8'd5);
        cwr(4'd0, 0, 19'h201, 8'd5, 0, 20'h11111, 3'd3, 1, 1, 20'h22222, 3'd2, 0, 1); tick("R5");
        look(32'h0040_2ABC, 8'd5); tick("R12");
        look(32'h0040_3ABC, 8'd5); tick("R12");
        look(32'h0040_2ABC, 8'd6); tick("R2");

        // slot 1: global, mask of two bits, odd page invalid
        cwr(4'd1, 19'h3, 19'h8000, 8'd9, 1, 20'h33330, 3'd5, 1, 1, 20'h44440, 3'd1, 0, 0); tick("R5");
        look(32'h1000_2123, 8'd0); tick("R1");
        look(32'h1000_6123, 8'd77); tick("R12");
        look(32'h1001_0000, 8'd9); tick("R1");

        // duplicate of slot 0 at slot 2, empty-valid slot 3, global slot 4
        cwr(4'd2, 0, 19'h201, 8'd5, 0, 20'h55555, 3'd0, 0, 1, 20'h66666, 3'd0, 0, 1); tick("R5");
        cwr(4'd3, 0, 19'h300, 8'd1, 1, 20'h0AAAA, 3'd0, 0, 0, 20'h0BBBB, 3'd0, 0, 0); tick("R5");
        look(32'h0040_2ABC, 8'd5); tick("R13");
        look(32'h0060_0010, 8'd1); tick("R4");
        cwr(4'd4, 0, 19'h201, 8'd2, 1, 20'h77777, 3'd4, 1, 1, 20'h78787, 3'd4, 0, 1); tick("R5");
        look(32'h0040_2ABC, 8'd7); tick("R2");

        // probes
        cpr(19'h201, 8'd5); tick("R3");
        cpr(19'h8002, 8'h33); tick("R3");
        cpr(19'h300, 8'd1); tick("R4");
        cpr(19'h123, 8'd5); tick("R3");

        // read-back layout
        crd(4'd0, 0); tick("R7");
        crd(4'd1, 0); tick("R7");
        crd(4'd4, 0); tick("R7");

        // out-of-range writes and read
        look(32'h0040_2ABC, 8'd5);
        cwr(4'd8, 0, 19'h201, 8'd5, 0, 20'h0DEAD, 3'd7, 1, 1, 20'h0BEEF, 3'd7, 1, 1); tick("R5");
        cwr(4'd15, 0, 19'h400, 8'd5, 1, 20'h0DEAD, 3'd7, 1, 1, 20'h0BEEF, 3'd7, 1, 1); tick("R5");
        crd(4'd9, 0); tick("R5");
        cpr(19'h400, 8'd5); tick("R5");
        crd(4'd0, 0); tick("R5");

        // replacement pointer
        for (int n = 0; n < 10; n++) begin
            crd(4'd0, 1); tick("R11");
        end
        crd(4'd6, 0); tick("R11");
        cpr(19'h201, 8'd5); tick("R11");
        crd(4'd0, 1); tick("R11");

        // uncached marking and physical mode
        look(32'hA000_1234, 8'd0, 1); tick("R9");
        look(32'h2000_0000, 8'd0, 1); tick("R8");
        look(32'hB040_2ABC, 8'd5); tick("R8");
        look(32'h8000_0000, 8'd5); tick("R8");
        look(32'hFFFF_FFFE, 8'd0, 1, 1, 4'd4); tick("R9");

        // wrap fault
        look(32'hFFFF_FFFE, 8'd0, 0, 1, 4'd4); tick("R10");
        look(32'hFFFF_FFFE, 8'd0, 0, 1, 4'd2); tick("R10");
        look(32'hFFFF_FFFE, 8'd0, 0, 0, 4'd4); tick("R10");
        look(32'h0040_2ABC, 8'd5, 0, 1, 4'd8); tick("R10");

        // write to slot 0 while looking it up
        look(32'h0040_2ABC, 8'd5);
        cwr(4'd0, 0, 19'h201, 8'd5, 0, 20'h12121, 3'd6, 0, 1, 20'h23232, 3'd6, 1, 1); tick("R5");
        look(32'h0040_2ABC, 8'd5); tick("R5");

        // flush while looking up, then empty
        crd(4'd0, 1); tick("R11");
        look(32'h0040_2ABC, 8'd5);
        cfl(); tick("R6");
        look(32'h0040_2ABC, 8'd5); tick("R6");
        look(32'h1000_2123, 8'd0); tick("R6");
        crd(4'd0, 1); tick("R6");
        cpr(19'h8000, 8'd9); tick("R6");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule